// File: doc/BRIEF.md
# Supervisor reset and watchdog controller

This controller turns a set of already-digitized supervisory conditions into a processor reset. It watches three things: a supply-below-threshold flag from an external comparator, an active-low manual-reset request, and a watchdog kick line that healthy firmware toggles. Whenever any of these calls for a reset, the controller asserts its reset outputs. After the last cause has gone, it keeps them asserted for a fixed hold time.

All time is measured in ticks of a prescaled enable, `tick`, so the hold time and the watchdog period are parameters counted in ticks. With a 1 kHz tick, the defaults give roughly 200 ms of hold and 1.6 s of watchdog period. The watchdog cannot be turned off. If the kick line sticks at either level, the result is a reset pulse that repeats once per watchdog period plus hold time.

Both reset polarities are provided as separate registered outputs. The manual-reset and kick inputs may be asynchronous and are synchronized inside the block. The supply flag is expected to arrive already in the clock domain.

Top module: `sup_reset_ctrl`

## Requirements
- R1: During the synchronous init `rst`, the reset outputs are asserted. After `rst` is released they stay asserted until exactly HOLD_TICKS ticks have elapsed, counting the first clock edge after release.
- R2: `supply_low` high at a clock edge asserts the reset outputs from that edge on. They stay asserted for as long as the flag stays high.
- R3: Once all causes are gone, reset deasserts on the HOLD_TICKS-th tick that follows. Clock edges without `tick` do not advance the hold time.
- R4: A cause that reappears while the hold time is running restarts the hold count from zero.
- R5: `mreset_n` passes through a two-stage synchronizer. Reset asserts on the third clock edge after `mreset_n` falls and stays asserted while it is low. It deasserts HOLD_TICKS ticks after the synchronized level returns high, which is HOLD_TICKS+2 edges when `tick` is present every cycle.
- R6: A rising edge and a falling edge of `kick` each clear the watchdog count. The clear lands three clock edges after the input change.
- R7: If no kick edge is seen for WDOG_TICKS ticks, the watchdog raises a one-cycle expiry, and the next edge asserts reset for one full hold time. With the kick line stuck, this repeats every WDOG_TICKS+HOLD_TICKS+1 edges when `tick` is present every cycle. No input disables it.
- R8: The watchdog count is held at zero for as long as reset is asserted. It begins counting only on the edge after reset deasserts.
- R9: `cpu_rst` is always the exact complement of `cpu_rst_n`.
- R10: A watchdog expiry that coincides with another cause forms a single reset event. The hold time is not lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high init; forces reset asserted with a fresh hold count |
| tick | input | 1 | Prescaled time-base enable; one pulse per counted tick |
| supply_low | input | 1 | Supply-below-threshold flag, already in the clock domain |
| mreset_n | input | 1 | Active-low manual reset request, asynchronous |
| kick | input | 1 | Watchdog kick line, asynchronous; any edge counts as a kick |
| cpu_rst_n | output | 1 | Registered active-low processor reset |
| cpu_rst | output | 1 | Registered active-high processor reset, complement of `cpu_rst_n` |

## Verification
Each result has a fixed latency when `tick` is present every cycle. A supply flag shows on the outputs one edge after it is sampled. A manual-reset change takes three edges, because of the two synchronizer stages plus the output register. Release comes HOLD_TICKS edges after the last cause edge. A watchdog expiry surfaces WDOG_TICKS+1 edges after the deassertion, or WDOG_TICKS+4 edges after the final kick change.

The bench drives every input and samples every output on falling edges. It steps an exact number of rising edges from each stimulus, and it checks both the last edge on which the old value must still hold and the first edge on which the new one is due. In the divided-tick case the exact phase is not fixed, so that check uses a window bounded by the whole-tick count.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Width of a counter that must hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= RST_VAL;
          else     pipe[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= RST_VAL;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/sup_stretch.sv
module sup_stretch
  import sup_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cause,
  output logic rst_q,
  output logic rst_n_q
);

  localparam int unsigned CW = cnt_w(HOLD_TICKS);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_q   <= 1'b1;
      rst_n_q <= 1'b0;
      cnt     <= '0;
    end else if (cause) begin
      rst_q   <= 1'b1;
      rst_n_q <= 1'b0;
      cnt     <= '0;
    end else if (rst_q && tick) begin
      if (cnt == LAST) begin
        rst_q   <= 1'b0;
        rst_n_q <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CAUSE_ASSERTS: assert property (@(posedge clk) disable iff (rst)
    cause |=> (rst_q && cnt == '0)); // R4

  AST_NO_RELEASE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    (rst_q && !tick) |=> rst_q); // R3

  AST_COUNT_ONLY_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
    !rst_q |-> cnt == '0); // R3

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
  import sup_pkg::*;
#(
  parameter int unsigned WDOG_TICKS = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hold,
  input  logic kick_s,
  output logic fire
);

  localparam int unsigned CW = cnt_w(WDOG_TICKS);
  localparam logic [CW-1:0] LAST = CW'(WDOG_TICKS - 1);

  logic [CW-1:0] cnt;
  logic          kick_d;
  logic          kick_edge;

  assign kick_edge = kick_s ^ kick_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      kick_d <= 1'b0;
      cnt    <= '0;
      fire   <= 1'b0;
    end else begin
      kick_d <= kick_s;
      fire   <= 1'b0;
      if (hold || kick_edge) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == LAST) begin
          cnt  <= '0;
          fire <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_WD_HELD_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    hold |=> cnt == '0); // R8

  AST_WD_EDGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    kick_edge |=> (cnt == '0 && !fire)); // R6

  AST_WD_FIRE_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(!hold)); // R8

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int unsigned HOLD_TICKS  = 200,
  parameter int unsigned WDOG_TICKS  = 1600,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic supply_low,
  input  logic mreset_n,
  input  logic kick,
  output logic cpu_rst_n,
  output logic cpu_rst
);

  logic [1:0] sync_in;
  logic [1:0] sync_out;
  logic       mr_s;
  logic       kick_s;
  logic       wd_fire;
  logic       cause;
  logic       held_q;
  logic       held_n_q;

  assign sync_in = {kick, mreset_n};

  sup_sync #(
    .WIDTH   (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b01)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (sync_in),
    .dout (sync_out)
  );

  assign mr_s   = sync_out[0];
  assign kick_s = sync_out[1];

  // All causes merge into one request, so coincident causes are one event.
  assign cause = supply_low | ~mr_s | wd_fire;

  sup_stretch #(
    .HOLD_TICKS (HOLD_TICKS)
  ) u_stretch (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cause   (cause),
    .rst_q   (held_q),
    .rst_n_q (held_n_q)
  );

  sup_wdog #(
    .WDOG_TICKS (WDOG_TICKS)
  ) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .hold   (held_q),
    .kick_s (kick_s),
    .fire   (wd_fire)
  );

  assign cpu_rst   = held_q;
  assign cpu_rst_n = held_n_q;

  AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    cpu_rst == !cpu_rst_n); // R9

  AST_SUPPLY_ASSERTS: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> (cpu_rst && !cpu_rst_n)); // R2

  AST_MANUAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !mr_s |=> cpu_rst); // R5

  AST_FIRE_ASSERTS: assert property (@(posedge clk) disable iff (rst)
    wd_fire |=> cpu_rst); // R7

endmodule

// File: tb/sim_sup_reset_ctrl.sv
module sim_sup_reset_ctrl;

  localparam int unsigned HOLD = 20;
  localparam int unsigned WD   = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic supply_low = 1'b0;
  logic mreset_n = 1'b1;
  logic kick;
  logic kick_auto = 1'b0;
  logic kick_man = 1'b0;
  logic auto_on = 1'b1;
  logic div_on = 1'b0;
  logic cpu_rst_n;
  logic cpu_rst;
  logic done = 1'b0;
  int   checks = 0;
  int   errors = 0;

  always #5 clk = ~clk;

  assign kick = auto_on ? kick_auto : kick_man;

  sup_reset_ctrl #(
    .HOLD_TICKS  (HOLD),
    .WDOG_TICKS  (WD),
    .SYNC_STAGES (2)
  ) u0 (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .supply_low (supply_low),
    .mreset_n   (mreset_n),
    .kick       (kick),
    .cpu_rst_n  (cpu_rst_n),
    .cpu_rst    (cpu_rst)
  );

  // Background kicker: toggles every 6 cycles while enabled.
  initial begin
    int kc = 0;
    forever begin
      @(negedge clk);
      kc++;
      if (kc == 6) begin
        kc = 0;
        kick_auto = ~kick_auto;
      end
    end
  end

  // Time base: every cycle, or every fourth cycle when dividing.
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      tick = !div_on || ((tc % 4) == 0);
    end
  end

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rst(input logic exp, input string req);
    checks++;
    if (cpu_rst !== exp || cpu_rst_n !== ~exp) begin
      errors++;
      $display("FAIL %s: cpu_rst=%b cpu_rst_n=%b expected cpu_rst=%b", req, cpu_rst, cpu_rst_n, exp);
    end
    checks++;
    if (cpu_rst !== ~cpu_rst_n) begin
      errors++;
      $display("FAIL R9: cpu_rst=%b cpu_rst_n=%b expected complements", cpu_rst, cpu_rst_n);
    end
  endtask

  task automatic t_power_on();
    edges(3);
    expect_rst(1'b1, "R1");
    rst = 1'b0;
    edges(HOLD - 1);
    expect_rst(1'b1, "R1");
    edges(1);
    expect_rst(1'b0, "R1");
  endtask

  task automatic t_supply();
    supply_low = 1'b1;
    edges(1);
    expect_rst(1'b1, "R2");
    edges(5);
    expect_rst(1'b1, "R2");
    supply_low = 1'b0;
    edges(HOLD - 1);
    expect_rst(1'b1, "R3");
    edges(1);
    expect_rst(1'b0, "R3");
  endtask

  task automatic t_dip_restart();
    supply_low = 1'b1;
    edges(1);
    supply_low = 1'b0;
    edges(10);
    expect_rst(1'b1, "R4");
    supply_low = 1'b1;
    edges(1);
    supply_low = 1'b0;
    edges(HOLD - 1);
    expect_rst(1'b1, "R4");
    edges(1);
    expect_rst(1'b0, "R4");
  endtask

  task automatic t_manual();
    mreset_n = 1'b0;
    edges(2);
    expect_rst(1'b0, "R5");
    edges(1);
    expect_rst(1'b1, "R5");
    edges(30);
    expect_rst(1'b1, "R5");
    mreset_n = 1'b1;
    edges(HOLD + 1);
    expect_rst(1'b1, "R5");
    edges(1);
    expect_rst(1'b0, "R5");
  endtask

  task automatic t_prescale();
    div_on = 1'b1;
    edges(2);
    supply_low = 1'b1;
    edges(4);
    supply_low = 1'b0;
    edges(4 * HOLD - 8);
    expect_rst(1'b1, "R3");
    edges(12);
    expect_rst(1'b0, "R3");
    div_on = 1'b0;
    edges(2);
  endtask

  // Leaves the bench just after a deassertion, with kick static.
  task automatic quiet_release();
    auto_on = 1'b0;
    edges(6);
    supply_low = 1'b1;
    edges(1);
    supply_low = 1'b0;
    edges(HOLD);
    expect_rst(1'b0, "R3");
  endtask

  task automatic t_stuck_kick();
    quiet_release();
    edges(WD);
    expect_rst(1'b0, "R7");
    edges(1);
    expect_rst(1'b1, "R7");
    edges(HOLD - 1);
    expect_rst(1'b1, "R7");
    edges(1);
    expect_rst(1'b0, "R7");
    edges(WD);
    expect_rst(1'b0, "R7");
    edges(1);
    expect_rst(1'b1, "R7");
    edges(HOLD);
    expect_rst(1'b0, "R7");
  endtask

  task automatic t_coincident();
    edges(WD);
    expect_rst(1'b0, "R10");
    supply_low = 1'b1;
    edges(1);
    supply_low = 1'b0;
    expect_rst(1'b1, "R10");
    edges(HOLD - 1);
    expect_rst(1'b1, "R10");
    edges(1);
    expect_rst(1'b0, "R10");
  endtask

  task automatic t_kick_edges();
    edges(WD - 10);
    kick_man = ~kick_man;
    edges(WD - 10);
    expect_rst(1'b0, "R6");
    kick_man = ~kick_man;
    edges(WD + 3);
    expect_rst(1'b0, "R6");
    edges(1);
    expect_rst(1'b1, "R7");
  endtask

  task automatic t_wd_held();
    mreset_n = 1'b0;
    edges(3 * WD);
    expect_rst(1'b1, "R8");
    mreset_n = 1'b1;
    edges(HOLD + 1);
    expect_rst(1'b1, "R8");
    edges(1);
    expect_rst(1'b0, "R8");
    edges(WD);
    expect_rst(1'b0, "R8");
    edges(1);
    expect_rst(1'b1, "R8");
    auto_on = 1'b1;
    edges(HOLD + 2);
    expect_rst(1'b0, "R6");
    edges(3 * WD);
    expect_rst(1'b0, "R6");
  endtask

  initial begin
    @(negedge clk);
    t_power_on();
    t_supply();
    t_dip_restart();
    t_manual();
    t_prescale();
    t_stuck_kick();
    t_coincident();
    t_kick_edges();
    t_wd_held();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule